// File: doc/BRIEF.md
# Dual-Mode Display Identification Memory

This block holds a 128-byte table of display identification data. It serves the table to a host in one of two ways. After reset it is a transmit-only source. Each rising edge of a dedicated stream clock pin advances one bit. The block sends the whole table as a serial stream, one byte after another, and the stream repeats without end. The serial data line is open-drain: the block only pulls it low, through an output enable.

The first falling edge on the two-wire bus clock line moves the block into a bidirectional two-wire slave mode, and it stays there until the next reset. In that mode a bus master addresses the block at 7-bit address 0x50. The master can load a word pointer, write bytes and read bytes. The pointer wraps around the 128 locations.

All pins are sampled into the system clock domain through a short synchroniser chain. Bus START and STOP conditions, as well as clock edges, are detected on the synchronised copies.

Top module: `idmem_top`

## Requirements
- R1: After reset, location i (0 to 127) holds the byte i XOR 0x5A.
- R2: Right after reset the block is in transmit-only mode and presents bit 7 of location 0, so `sda_oe` is 1 (that bit is 0).
- R3: In transmit-only mode each synchronised rising edge of `stream_clk` advances one bit. A byte goes out bit 7 first, down to bit 0, and is followed by one idle bit that is always 1. A 0 bit sets `sda_oe` to 1 and a 1 bit sets it to 0.
- R4: The stream goes from the idle bit of location 127 to bit 7 of location 0 and repeats continuously.
- R5: A falling edge on `scl_in` switches the block into bidirectional mode. From then on `sda_oe` is 0 except during acknowledge and read-data bits, until the next reset.
- R6: In bidirectional mode, edges on `stream_clk` have no effect on `sda_oe`.
- R7: The block acknowledges only a first byte whose upper seven bits equal 0x50; bit 0 of that byte is the direction (1 = read). Any other address is not acknowledged, and the block ignores the bus until the next START.
- R8: In a write, the first byte after the address loads the word pointer from its low 7 bits. Every later byte is stored at the pointer, and the pointer then increments modulo 128. Every byte is acknowledged by pulling SDA low during the ninth clock.
- R9: A read returns the byte at the word pointer, bit 7 first, and the pointer increments modulo 128 after each byte. When the master acknowledges, the next byte follows. When it does not acknowledge, the read ends and SDA is released.
- R10: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP, and after a STOP no byte is acknowledged until a new START.
- R11: Reset returns the block to transmit-only mode at bit 7 of location 0 with the initial contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_clk | input | 1 | Bit clock for transmit-only mode |
| scl_in | input | 1 | Two-wire bus clock as seen on the pin |
| sda_in | input | 1 | Two-wire bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The checks assume that `stream_clk`, `scl_in` and `sda_in` are slow compared with the system clock. Each level must last several system cycles, so that every edge passes the synchroniser chain before the next edge arrives. The checks also assume that the master changes SDA only while SCL is low, except to form START and STOP. The bench holds each stream clock level for four system cycles and each bus clock phase for ten. It moves SDA two cycles after SCL falls, so that SCL and SDA never change together.

// File: rtl/idmem_pkg.sv
package idmem_pkg;

   typedef enum logic [2:0] {
      TW_IDLE,
      TW_DEVADR,
      TW_PTR,
      TW_WDATA,
      TW_ACK,
      TW_RDATA,
      TW_RACK
   } tw_state_t;

   // power-up content of one location
   function automatic logic [7:0] init_byte(input int unsigned idx, input logic [7:0] seed);
      return 8'(idx) ^ seed;
   endfunction

endpackage

// File: rtl/idmem_sync.sv
module idmem_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 2) begin : g_pair
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[0], d};
         end
      end else begin : g_long
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/idmem_stream.sv
module idmem_stream #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [3:0]        bit_pos,
   output logic              out_bit
);
   localparam logic [3:0] LAST_POS = 4'd8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr <= '0;
         bit_pos <= '0;
      end else if (adv) begin
         if (bit_pos == LAST_POS) begin
            bit_pos <= '0;
            rd_addr <= rd_addr + 1'b1;
         end else begin
            bit_pos <= bit_pos + 4'd1;
         end
      end
   end

   always_comb begin
      if (bit_pos == LAST_POS) out_bit = 1'b1;
      else                     out_bit = rd_data[3'(4'd7 - bit_pos)];
   end
endmodule

// File: rtl/idmem_twi_slave.sv
module idmem_twi_slave
   import idmem_pkg::*;
#(
   parameter int          ADDR_W   = 7,
   parameter logic [6:0]  DEV_ADDR = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_en,
   output logic [7:0]        wr_data,
   output logic              sda_pull
);
   tw_state_t   st, after_ack;
   logic [7:0]  sh;
   logic [3:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= TW_IDLE;
         after_ack <= TW_IDLE;
         sh        <= '0;
         cnt       <= '0;
         ptr       <= '0;
      end else if (!enable) begin
         st <= TW_IDLE;
      end else if (start_det) begin
         st  <= TW_DEVADR;
         cnt <= '0;
      end else if (stop_det) begin
         st <= TW_IDLE;
      end else begin
         case (st)
            TW_DEVADR, TW_PTR, TW_WDATA: begin
               if (scl_rise && cnt < 4'd8) begin
                  sh  <= {sh[6:0], sda_s};
                  cnt <= cnt + 4'd1;
               end else if (scl_fall && cnt == 4'd8) begin
                  cnt <= '0;
                  if (st == TW_DEVADR) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        st        <= TW_ACK;
                        after_ack <= sh[0] ? TW_RDATA : TW_PTR;
                     end else begin
                        st <= TW_IDLE;
                     end
                  end else if (st == TW_PTR) begin
                     ptr       <= sh[ADDR_W-1:0];
                     st        <= TW_ACK;
                     after_ack <= TW_WDATA;
                  end else begin
                     ptr       <= ptr + 1'b1;
                     st        <= TW_ACK;
                     after_ack <= TW_WDATA;
                  end
               end
            end
            TW_ACK: begin
               if (scl_fall) begin
                  st  <= after_ack;
                  cnt <= '0;
                  if (after_ack == TW_RDATA) sh <= rd_data;
               end
            end
            TW_RDATA: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     st  <= TW_RACK;
                     ptr <= ptr + 1'b1;
                  end else begin
                     sh  <= {sh[6:0], 1'b0};
                     cnt <= cnt + 4'd1;
                  end
               end
            end
            TW_RACK: begin
               if (scl_rise && sda_s) begin
                  st <= TW_IDLE;
               end else if (scl_fall) begin
                  sh  <= rd_data;
                  cnt <= '0;
                  st  <= TW_RDATA;
               end
            end
            default: st <= TW_IDLE;
         endcase
      end
   end

   assign wr_en    = enable && !start_det && !stop_det && (st == TW_WDATA)
                     && scl_fall && (cnt == 4'd8);
   assign wr_data  = sh;
   assign sda_pull = enable && ((st == TW_ACK) || ((st == TW_RDATA) && !sh[7]));
endmodule

// File: rtl/idmem_top.sv
module idmem_top
   import idmem_pkg::*;
#(
   parameter int          ADDR_W      = 7,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'h50,
   parameter logic [7:0]  INIT_SEED   = 8'h5A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stream_clk,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_oe
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("idmem_top: DATA_W must be 8 for byte transfers");
      end
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_depth
         $error("idmem_top: ADDR_W must lie in 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("idmem_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic stm_s, scl_s, sda_s;
   logic stm_p, scl_p, sda_p;

   idmem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_stm (
      .clk(clk), .rst_n(rst_n), .d(stream_clk), .q(stm_s));
   idmem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   idmem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stm_p <= 1'b0;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         stm_p <= stm_s;
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   assign scl_rise  = !scl_p && scl_s;
   assign scl_fall  = scl_p && !scl_s;
   assign start_det = scl_p && scl_s && sda_p && !sda_s;
   assign stop_det  = scl_p && scl_s && !sda_p && sda_s;

   // one-way mode flag
   logic mode_bidir;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_bidir <= 1'b0;
      else if (scl_fall) mode_bidir <= 1'b1;
   end

   logic stream_adv;
   assign stream_adv = !mode_bidir && stm_s && !stm_p;

   // storage array
   logic [7:0]        mem [DEPTH];
   logic [ADDR_W-1:0] s_addr, t_ptr;
   logic [3:0]        s_bit;
   logic              s_out;
   logic              wr_en;
   logic [7:0]        wr_data;
   logic              t_pull;
   logic [7:0]        s_rd, t_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i, INIT_SEED);
      end else if (wr_en) begin
         mem[t_ptr] <= wr_data;
      end
   end

   assign s_rd = mem[s_addr];
   assign t_rd = mem[t_ptr];

   idmem_stream #(.ADDR_W(ADDR_W)) u_stream (
      .clk(clk), .rst_n(rst_n), .adv(stream_adv), .rd_data(s_rd),
      .rd_addr(s_addr), .bit_pos(s_bit), .out_bit(s_out));

   idmem_twi_slave #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_twi (
      .clk(clk), .rst_n(rst_n), .enable(mode_bidir),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det), .rd_data(t_rd),
      .ptr(t_ptr), .wr_en(wr_en), .wr_data(wr_data), .sda_pull(t_pull));

   logic [ADDR_W+3:0] stream_pos;
   assign stream_pos = {s_addr, s_bit};

   assign sda_oe = mode_bidir ? t_pull : !s_out;
endmodule

// File: rtl/idmem_chk.sv
module idmem_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bidir,
   input logic              scl_fall,
   input logic              stream_adv,
   input logic [ADDR_W+3:0] stream_pos,
   input logic              wr_en,
   input logic              sda_oe
);
   AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      bidir |=> bidir); // R5
   AST_SWITCH_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!bidir && scl_fall) |=> bidir); // R5
   AST_STREAM_FROZEN_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
      bidir |=> $stable(stream_pos)); // R6
   AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bidir && !stream_adv) |=> $stable(stream_pos)); // R3
   AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      stream_adv |=> (stream_pos != $past(stream_pos))); // R3
   AST_IDLE_BIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (!bidir && stream_pos[3:0] == 4'd8) |-> !sda_oe); // R3
   AST_WRITE_ONLY_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> bidir); // R8
endmodule

bind idmem_top idmem_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bidir(mode_bidir), .scl_fall(scl_fall),
   .stream_adv(stream_adv), .stream_pos(stream_pos), .wr_en(wr_en),
   .sda_oe(sda_oe));

// File: tb/idmem_top_tb_top.sv
module idmem_top_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stream_clk = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   localparam int H = 10;

   always #10 clk = ~clk;   // 50 MHz

   assign sda_line = sda_m & ~sda_oe;

   idmem_top dut_i (
      .clk(clk), .rst_n(rst_n), .stream_clk(stream_clk),
      .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe));

   // {edges to apply, requirement number, expected sda_oe}
   localparam int NV = 19;
   localparam logic [20:0] VEC [NV] = '{
      {16'd0,    4'd3, 1'b1},  // byte 0 bit7
      {16'd1,    4'd3, 1'b0},
      {16'd1,    4'd3, 1'b1},
      {16'd1,    4'd3, 1'b0},
      {16'd1,    4'd3, 1'b0},
      {16'd1,    4'd3, 1'b1},
      {16'd1,    4'd3, 1'b0},
      {16'd1,    4'd3, 1'b1},  // byte 0 bit0
      {16'd1,    4'd3, 1'b0},  // idle bit
      {16'd1,    4'd3, 1'b1},  // byte 1 bit7
      {16'd7,    4'd3, 1'b0},  // byte 1 bit0
      {16'd1,    4'd3, 1'b0},  // idle bit
      {16'd1,    4'd3, 1'b1},  // byte 2 bit7
      {16'd1130, 4'd4, 1'b0},  // byte 127 bit2
      {16'd1,    4'd4, 1'b1},
      {16'd1,    4'd4, 1'b0},
      {16'd1,    4'd4, 1'b0},  // idle after 127
      {16'd1,    4'd4, 1'b1},  // wrapped: byte 0 bit7
      {16'd1,    4'd4, 1'b0}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic stream_edges(input int n);
      for (int k = 0; k < n; k++) begin
         stream_clk = 1'b1; tick(4);
         stream_clk = 1'b0; tick(4);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(2);
      scl = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(H);
         scl = 1'b1; tick(H);
         scl = 1'b0; tick(2);
      end
      sda_m = 1'b1; tick(H);
      scl = 1'b1; tick(H / 2);
      acked = (sda_line == 1'b0);
      tick(H / 2);
      scl = 1'b0; tick(2);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H);
         scl = 1'b1; tick(H / 2);
         b[i] = sda_line;
         tick(H / 2);
         scl = 1'b0; tick(2);
      end
      sda_m = ~give_ack; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   initial begin
      logic       ak;
      logic [7:0] rb;
      tick(3);
      rst_n = 1'b1;
      tick(3);
      // R2: reset state, transmit-only at bit 7 of location 0
      check("R2 reset oe", 32'(sda_oe), 32'd1);

      // R3 / R4: stream vectors
      for (int v = 0; v < NV; v++) begin
         stream_edges(int'(VEC[v][20:5]));
         check($sformatf("R%0d stream vec %0d", VEC[v][4:1], v), 32'(sda_oe), 32'(VEC[v][0]));
      end

      // R5: switch on SCL falling edge
      stream_edges(1);
      check("R3 byte0 bit5 before switch", 32'(sda_oe), 32'd1);
      scl = 1'b0; tick(H);
      check("R5 released after scl fall", 32'(sda_oe), 32'd0);
      scl = 1'b1; tick(H);

      // R6: stream clock ignored
      stream_edges(3);
      check("R6 stream edges ignored", 32'(sda_oe), 32'd0);

      // R7: wrong device address not acknowledged
      bus_start();
      send_byte({7'h51, 1'b0}, ak);
      check("R7 wrong address nack", 32'(ak), 32'd0);
      bus_stop();

      // R8: pointer load and writes across the wrap
      bus_start();
      send_byte(8'hA0, ak);  check("R7 address ack", 32'(ak), 32'd1);
      send_byte(8'h7E, ak);  check("R8 pointer ack", 32'(ak), 32'd1);
      send_byte(8'h11, ak);  check("R8 data ack 7E", 32'(ak), 32'd1);
      send_byte(8'h22, ak);  check("R8 data ack 7F", 32'(ak), 32'd1);
      send_byte(8'h33, ak);  check("R8 data ack 00", 32'(ak), 32'd1);
      bus_stop();

      // R9: sequential read across the wrap with repeated start
      bus_start();
      send_byte(8'hA0, ak);
      send_byte(8'h7F, ak);
      bus_start();
      send_byte(8'hA1, ak);  check("R9 read address ack", 32'(ak), 32'd1);
      recv_byte(1'b1, rb);   check("R9 read 7F", 32'(rb), 32'h22);
      recv_byte(1'b1, rb);   check("R9 read wraps to 00", 32'(rb), 32'h33);
      recv_byte(1'b0, rb);   check("R9 read 01 untouched", 32'(rb), 32'h01 ^ 32'h5A);
      tick(H);
      check("R9 released after nack", 32'(sda_oe), 32'd0);
      bus_stop();

      // R1: initial content at a middle location, current-address read
      bus_start();
      send_byte(8'hA0, ak);
      send_byte(8'h40, ak);
      bus_start();
      send_byte(8'hA1, ak);
      recv_byte(1'b0, rb);   check("R1 initial content 40", 32'(rb), 32'h40 ^ 32'h5A);
      bus_stop();
      bus_start();
      send_byte(8'hA1, ak);
      recv_byte(1'b0, rb);   check("R9 pointer advanced to 41", 32'(rb), 32'h41 ^ 32'h5A);
      bus_stop();

      // R10: after STOP nothing is acknowledged without a new START
      bus_start();
      send_byte(8'hA0, ak);
      bus_stop();
      scl = 1'b0; tick(2);
      send_byte(8'hA0, ak);
      check("R10 no ack after stop", 32'(ak), 32'd0);
      bus_stop();

      // R11: reset brings back transmit-only mode and contents
      rst_n = 1'b0; tick(3);
      rst_n = 1'b1; tick(3);
      check("R11 reset oe", 32'(sda_oe), 32'd1);
      stream_edges(1);
      check("R11 stream runs again", 32'(sda_oe), 32'd0);
      stream_edges(8);
      check("R11 byte1 bit7", 32'(sda_oe), 32'd1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule